// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small RISC-style core. Each cycle it takes two operands, an operation code and the current carry bit. It returns the result byte and the next values of six status flags: half-carry, sign, overflow, negative, zero and carry. Each flag comes with its own write-enable. The core's status register writes only the flags whose enable is high, so every flag that an operation does not affect keeps its old value.

The unit covers add and subtract, each with and without the incoming carry. It also covers the bitwise AND, OR and XOR, the ones and twos complement, increment and decrement, the left shift, the logical and arithmetic right shifts, the rotates through carry, and the nibble swap. A decoder built on a `unique case` maps each operation onto one of three datapaths: a shared adder/subtractor, a bitwise unit and a shifter. The same decoder picks the flag-write mask, and a common stage then forms the flags from the chosen result. There is no state, so the house state machine becomes this decode step. Its "states" are the datapath selections PASS, ARITH, LOGIC and SHIFT. The operation code picks one of them in each cycle, and no selection depends on an earlier one.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 (add) gives a+b and code 1 (add with carry) gives a+b+carry_i, both modulo 256. All six flags are written. C is the carry out of bit 7, H is the carry out of bit 3, and V is high when both operands have the same sign and the result has the other sign.
- R2: Code 2 (subtract) gives a-b and code 3 (subtract with carry) gives a-b-carry_i, both modulo 256. All six flags are written. C is high when the operation borrows past bit 7, H is high when it borrows into bit 4, and V is high when the operands differ in sign and the result's sign differs from that of a.
- R3: Codes 4, 5 and 6 (AND, OR, XOR) write only S, V, N and Z, and V is 0.
- R4: Code 7 (ones complement) gives 0xFF-a, sets C to 1 and V to 0, and writes S, V, N, Z and C but not H.
- R5: Code 8 (twos complement) gives 0x00-a and writes all six flags. C is high when the result is not 0, H is high when a[3:0] is not 0, and V is high when the result is 0x80.
- R6: Code 9 (increment) gives a+1 and code 10 (decrement) gives a-1, both modulo 256. They write only S, V, N and Z, so carry and half-carry are kept. V is high only for 0x7F to 0x80 on increment and 0x80 to 0x7F on decrement.
- R7: Code 11 shifts left with a zero into bit 0. Code 12 shifts right with a zero into bit 7. Code 13 shifts right and keeps bit 7. For each of them C takes the bit shifted out.
- R8: Code 14 rotates left through carry: carry_i goes into bit 0 and bit 7 goes to C. Code 15 rotates right through carry: carry_i goes into bit 7 and bit 0 goes to C.
- R9: Codes 11 to 15 write S, V, N, Z and C but not H, with V equal to N XOR C of the new result.
- R10: Code 16 swaps bits 7..4 with bits 3..0 and writes no flag.
- R11: N is always result bit 7 and Z is high when the result is 0. S equals N XOR V in every operation that writes S, and S is written exactly when N and V are.
- R12: flag_o and flag_we_o put the flags in the order bit 5 H, bit 4 S, bit 3 V, bit 2 N, bit 1 Z, bit 0 C. A flag that is not written reads 0 on flag_o. Operands an operation does not use, such as b in codes 7 to 16, have no effect.
- R13: Codes 17 to 31 pass a through unchanged and write no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand, the only operand for one-operand codes |
| b_i | input | 8 | Second operand |
| op_i | input | 5 | Operation code |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 8 | Result byte |
| flag_o | output | 6 | Next flag values {H,S,V,N,Z,C} |
| flag_we_o | output | 6 | Per-flag write-enable, same order |

## Verification
The hardest cases to reach are at the boundaries of the carry chain. These are a half-carry or half-borrow just at the nibble boundary, made worse by an incoming carry, and signed overflow at the 0x7F/0x80 edge. A few random pairs would rarely land on both at once. The stimulus therefore sweeps every value of a against a fixed set of second operands clustered on those edges (0x0F, 0x10, 0x7F, 0x80, 0x81, 0xFF and others). It does this for both values of carry_i. One-operand codes are driven with carry_i high and a changing b, so that a kept carry or a leak from an ignored operand shows up on the outputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W   = 5;
    localparam int FL_CNT = 6;

    // flag positions, matching the low six bits of the status register
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    localparam logic [FL_CNT-1:0] MASK_NONE  = 6'b000000;
    localparam logic [FL_CNT-1:0] MASK_ALL   = 6'b111111;
    localparam logic [FL_CNT-1:0] MASK_SVNZ  = 6'b011110;
    localparam logic [FL_CNT-1:0] MASK_SVNZC = 6'b011111;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ASR  = 5'd13,
        OP_ROL  = 5'd14,
        OP_ROR  = 5'd15,
        OP_SWAP = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        U_PASS,
        U_ARITH,
        U_LOGIC,
        U_SHIFT
    } unit_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_COM
    } logic_sel_e;

    typedef enum logic [2:0] {
        SH_LSL,
        SH_LSR,
        SH_ASR,
        SH_ROL,
        SH_ROR,
        SH_SWAP
    } shift_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         h_o,
    output logic         v_o
);
    localparam int HB = W / 2;

    logic [W:0]    wide;
    logic [HB:0]   low;
    logic [W:0]    cin_w;
    logic [HB:0]   cin_l;
    logic [W-1:0]  undo;

    assign cin_w = {{W{1'b0}}, cin_i};
    assign cin_l = {{HB{1'b0}}, cin_i};

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i} - cin_w;
            low  = {1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - cin_l;
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i} + cin_w;
            low  = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + cin_l;
        end
    end

    assign res_o = wide[W-1:0];
    assign c_o   = wide[W];
    assign h_o   = low[HB];
    assign v_o   = sub_i ? ((a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1]))
                         : ((a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1]));

    // inverse operation recovers the first operand
    always_comb begin
        if (sub_i) undo = res_o + b_i + cin_w[W-1:0];
        else       undo = res_o - b_i - cin_w[W-1:0];
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i, sub_i})) begin
            // R1 R2
            inverse_recovers_a_chk: assert (undo == a_i);
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] res_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign res_o[i] = (sel_i == LG_AND) ? (a_i[i] & b_i[i]) :
                          (sel_i == LG_OR)  ? (a_i[i] | b_i[i]) :
                          (sel_i == LG_XOR) ? (a_i[i] ^ b_i[i]) :
                                              ~a_i[i];
    end

    always_comb begin
        if (!$isunknown({a_i, sel_i}) && sel_i == LG_COM) begin
            // R4
            com_sum_ones_chk: assert ((res_o + a_i) == {W{1'b1}});
        end
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  shift_sel_e   sel_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    localparam int HB = W / 2;

    always_comb begin
        res_o = a_i;
        c_o   = 1'b0;
        unique case (sel_i)
            SH_LSL:  begin res_o = {a_i[W-2:0], 1'b0};      c_o = a_i[W-1]; end
            SH_LSR:  begin res_o = {1'b0, a_i[W-1:1]};      c_o = a_i[0];   end
            SH_ASR:  begin res_o = {a_i[W-1], a_i[W-1:1]};  c_o = a_i[0];   end
            SH_ROL:  begin res_o = {a_i[W-2:0], cin_i};     c_o = a_i[W-1]; end
            SH_ROR:  begin res_o = {cin_i, a_i[W-1:1]};     c_o = a_i[0];   end
            SH_SWAP: begin res_o = {a_i[HB-1:0], a_i[W-1:HB]}; c_o = 1'b0;  end
            default: begin res_o = a_i;                     c_o = 1'b0;     end
        endcase
    end

    always_comb begin
        if (!$isunknown({a_i, cin_i, sel_i})) begin
            if (sel_i == SH_ROL) begin
                // R8
                rol_through_carry_chk: assert ({c_o, res_o} == {a_i, cin_i});
            end
            if (sel_i == SH_ROR) begin
                // R8
                ror_through_carry_chk: assert ({res_o, c_o} == {cin_i, a_i});
            end
            if (sel_i == SH_SWAP) begin
                // R10
                swap_twice_chk: assert ({res_o[HB-1:0], res_o[W-1:HB]} == a_i);
            end
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              carry_i,
    output logic [W-1:0]      res_o,
    output logic [FL_CNT-1:0] flag_o,
    output logic [FL_CNT-1:0] flag_we_o
);
    alu_op_e           op_e;
    unit_e             unit;
    logic              as_sub;
    logic [W-1:0]      as_a;
    logic [W-1:0]      as_b;
    logic              as_cin;
    logic_sel_e        lg_sel;
    shift_sel_e        sh_sel;
    logic [FL_CNT-1:0] wmask;

    logic [W-1:0]      as_res;
    logic              as_c;
    logic              as_h;
    logic              as_v;
    logic [W-1:0]      lg_res;
    logic [W-1:0]      sh_res;
    logic              sh_c;

    logic              fh, fs, fv, fn, fz, fc;
    logic [FL_CNT-1:0] fl_all;

    assign op_e = alu_op_e'(op_i);

    // decode: pick datapath, its controls and the flag-write mask
    always_comb begin
        unit   = U_PASS;
        as_sub = 1'b0;
        as_a   = a_i;
        as_b   = b_i;
        as_cin = 1'b0;
        lg_sel = LG_AND;
        sh_sel = SH_LSL;
        wmask  = MASK_NONE;
        unique case (op_e)
            OP_ADD:  begin unit = U_ARITH; wmask = MASK_ALL; end
            OP_ADC:  begin unit = U_ARITH; as_cin = carry_i; wmask = MASK_ALL; end
            OP_SUB:  begin unit = U_ARITH; as_sub = 1'b1; wmask = MASK_ALL; end
            OP_SBC:  begin unit = U_ARITH; as_sub = 1'b1; as_cin = carry_i; wmask = MASK_ALL; end
            OP_AND:  begin unit = U_LOGIC; lg_sel = LG_AND; wmask = MASK_SVNZ; end
            OP_OR:   begin unit = U_LOGIC; lg_sel = LG_OR;  wmask = MASK_SVNZ; end
            OP_XOR:  begin unit = U_LOGIC; lg_sel = LG_XOR; wmask = MASK_SVNZ; end
            OP_COM:  begin unit = U_LOGIC; lg_sel = LG_COM; wmask = MASK_SVNZC; end
            OP_NEG:  begin
                unit = U_ARITH; as_sub = 1'b1; as_a = '0; as_b = a_i; wmask = MASK_ALL;
            end
            OP_INC:  begin unit = U_ARITH; as_b = '0; as_cin = 1'b1; wmask = MASK_SVNZ; end
            OP_DEC:  begin
                unit = U_ARITH; as_sub = 1'b1; as_b = '0; as_cin = 1'b1; wmask = MASK_SVNZ;
            end
            OP_LSL:  begin unit = U_SHIFT; sh_sel = SH_LSL; wmask = MASK_SVNZC; end
            OP_LSR:  begin unit = U_SHIFT; sh_sel = SH_LSR; wmask = MASK_SVNZC; end
            OP_ASR:  begin unit = U_SHIFT; sh_sel = SH_ASR; wmask = MASK_SVNZC; end
            OP_ROL:  begin unit = U_SHIFT; sh_sel = SH_ROL; wmask = MASK_SVNZC; end
            OP_ROR:  begin unit = U_SHIFT; sh_sel = SH_ROR; wmask = MASK_SVNZC; end
            OP_SWAP: begin unit = U_SHIFT; sh_sel = SH_SWAP; wmask = MASK_NONE; end
            default: begin unit = U_PASS; wmask = MASK_NONE; end
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a_i   (as_a),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .res_o (as_res),
        .c_o   (as_c),
        .h_o   (as_h),
        .v_o   (as_v)
    );

    alu8_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (lg_sel),
        .res_o (lg_res)
    );

    alu8_shift #(.W(W)) u_shift (
        .a_i   (a_i),
        .cin_i (carry_i),
        .sel_i (sh_sel),
        .res_o (sh_res),
        .c_o   (sh_c)
    );

    // result select and flag formation
    always_comb begin
        unique case (unit)
            U_ARITH: res_o = as_res;
            U_LOGIC: res_o = lg_res;
            U_SHIFT: res_o = sh_res;
            default: res_o = a_i;
        endcase
    end

    assign fn = res_o[W-1];
    assign fz = ~|res_o;

    always_comb begin
        fh = 1'b0;
        fv = 1'b0;
        fc = 1'b0;
        unique case (unit)
            U_ARITH: begin fh = as_h; fv = as_v; fc = as_c; end
            U_LOGIC: begin fc = (lg_sel == LG_COM); end
            U_SHIFT: begin fc = sh_c; fv = fn ^ sh_c; end
            default: begin fh = 1'b0; end
        endcase
    end

    assign fs = fn ^ fv;

    always_comb begin
        fl_all       = '0;
        fl_all[FL_H] = fh;
        fl_all[FL_S] = fs;
        fl_all[FL_V] = fv;
        fl_all[FL_N] = fn;
        fl_all[FL_Z] = fz;
        fl_all[FL_C] = fc;
    end

    assign flag_we_o = wmask;
    assign flag_o    = fl_all & wmask;

    always_comb begin
        if (!$isunknown({a_i, b_i, op_i, carry_i})) begin
            if (unit == U_SHIFT && flag_we_o[FL_V]) begin
                // R9
                shift_v_nxc_chk: assert (flag_o[FL_V] == (res_o[W-1] ^ flag_o[FL_C]));
            end
            if (op_e == OP_SWAP) begin
                // R10
                swap_no_flags_chk: assert (flag_we_o == MASK_NONE);
            end
            if (op_e == OP_INC || op_e == OP_DEC) begin
                // R6
                incdec_keep_carry_chk: assert (!flag_we_o[FL_C] && !flag_we_o[FL_H]);
            end
            if (flag_we_o[FL_S]) begin
                // R11
                sign_with_nv_chk: assert (flag_we_o[FL_N] && flag_we_o[FL_V]);
            end
            if (unit == U_LOGIC) begin
                // R3
                logic_v_clear_chk: assert (!flag_o[FL_V] && !flag_o[FL_H]);
            end
        end
    end

endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;

    logic       clk = 1'b0;
    logic [7:0] a_s = 8'h00;
    logic [7:0] b_s = 8'h00;
    logic [4:0] op_s = 5'd0;
    logic       c_s = 1'b0;
    logic [7:0] res;
    logic [5:0] flg;
    logic [5:0] we;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu8_core #(.W(8)) u0 (
        .a_i       (a_s),
        .b_i       (b_s),
        .op_i      (op_s),
        .carry_i   (c_s),
        .res_o     (res),
        .flag_o    (flg),
        .flag_we_o (we)
    );

    function automatic string req_tag(input int op);
        if (op <= 1)  return "R1";
        if (op <= 3)  return "R2";
        if (op <= 6)  return "R3";
        if (op == 7)  return "R4";
        if (op == 8)  return "R5";
        if (op <= 10) return "R6";
        if (op <= 13) return "R7/R9";
        if (op <= 15) return "R8/R9";
        if (op == 16) return "R10";
        return "R13";
    endfunction

    // expected values from the requirements (R11, R12 for flag layout)
    task automatic model(input int op, input int a, input int b, input int c,
                         output logic [7:0] er, output logic [5:0] ef, output logic [5:0] ew);
        int r, t, h, v, cc, n, z, s, ci;
        logic [5:0] w;
        h = 0; v = 0; cc = 0; r = a; w = 6'b000000;
        ci = (op == 1 || op == 3) ? c : 0;
        case (op)
            0, 1: begin
                t = a + b + ci; r = t & 255; cc = t >> 8;
                h = ((a & 15) + (b & 15) + ci) >> 4;
                v = (((a ^ r) & (b ^ r) & 128) != 0) ? 1 : 0;
                w = 6'b111111;
            end
            2, 3: begin
                t = a - b - ci; r = t & 255; cc = (t < 0) ? 1 : 0;
                h = (((a & 15) - (b & 15) - ci) < 0) ? 1 : 0;
                v = (((a ^ b) & (a ^ r) & 128) != 0) ? 1 : 0;
                w = 6'b111111;
            end
            4: begin r = a & b; w = 6'b011110; end
            5: begin r = a | b; w = 6'b011110; end
            6: begin r = a ^ b; w = 6'b011110; end
            7: begin r = 255 - a; cc = 1; w = 6'b011111; end
            8: begin
                r = (256 - a) & 255; cc = (r != 0) ? 1 : 0;
                h = ((a & 15) != 0) ? 1 : 0; v = (r == 128) ? 1 : 0;
                w = 6'b111111;
            end
            9:  begin r = (a + 1) & 255;   v = (a == 127) ? 1 : 0; w = 6'b011110; end
            10: begin r = (a + 255) & 255; v = (a == 128) ? 1 : 0; w = 6'b011110; end
            11: begin r = (a * 2) & 255;         cc = a >> 7; end
            12: begin r = a >> 1;                cc = a & 1;  end
            13: begin r = (a >> 1) | (a & 128);  cc = a & 1;  end
            14: begin r = ((a * 2) & 255) | c;   cc = a >> 7; end
            15: begin r = (a >> 1) | (c * 128);  cc = a & 1;  end
            16: begin r = ((a & 15) * 16) | (a >> 4); end
            default: begin r = a; end
        endcase
        n = (r >> 7) & 1;
        z = (r == 0) ? 1 : 0;
        if (op >= 11 && op <= 15) begin
            v = n ^ cc;
            w = 6'b011111;
        end
        s = n ^ v;
        er = 8'(r);
        ew = w;
        ef = {h[0], s[0], v[0], n[0], z[0], cc[0]} & w;
    endtask

    task automatic apply(input int op, input int a, input int b, input int c);
        logic [7:0] er;
        logic [5:0] ef, ew;
        @(posedge clk);
        op_s = 5'(op); a_s = 8'(a); b_s = 8'(b); c_s = c[0];
        @(negedge clk);
        model(op, a, b, c, er, ef, ew);
        vectors++;
        if (res !== er || flg !== ef || we !== ew) begin
            miscompares++;
            $display("FAIL %s op=%0d a=%02h b=%02h c=%0d: got res=%02h flags=%06b we=%06b, expected res=%02h flags=%06b we=%06b",
                     req_tag(op), op, a, b, c, res, flg, we, er, ef, ew);
        end
    endtask

    int blist[16] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h11, 8'h3C, 8'h55,
                      8'h7E, 8'h7F, 8'h80, 8'h81, 8'hAA, 8'hC3, 8'hF0, 8'hFF};

    initial begin
        // R1 R11 R12: all-zero inputs give zero result with only Z set
        apply(0, 0, 0, 0);
        // R1 R2 R3: two-operand codes, every a against boundary b values
        for (int op = 0; op <= 6; op++)
            for (int c = 0; c <= 1; c++)
                for (int bi = 0; bi < 16; bi++)
                    for (int a = 0; a < 256; a++)
                        apply(op, a, blist[bi], c);
        // R4..R10 R12: one-operand codes, b varies and must be ignored
        for (int op = 7; op <= 16; op++)
            for (int c = 0; c <= 1; c++)
                for (int a = 0; a < 256; a++)
                    apply(op, a, a ^ 8'h5A, c);
        // R13: unused codes pass a and write nothing
        for (int op = 17; op <= 31; op++)
            for (int a = 0; a < 256; a += 17)
                apply(op, a, 255 - a, op & 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(150000 * 4);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R1: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule